// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Channel

This block drives one inverter leg. A triangular time base counts from zero up to a programmable period value and back down, so one switching period spans twice the period value in clock cycles. Two compare units turn the count into raw waves. Wave A rises when the count climbs through its compare value and falls when the count descends through it. Wave B does the opposite. A dead-band stage derives an active-high complementary pair from wave A. The high-side output rises only after a programmable delay following each rising edge of A. The low-side output rises only after a separate programmable delay following each falling edge of A.

Software writes the period and both compare values into holding registers. The active copies take the new values only when the count sits at zero, so an update mid-period never distorts the current pulse. A channel with phase loading disabled acts as a master and pulses its sync output in the last cycle before the count returns to zero. A channel with phase loading enabled acts as a slave: it loads its phase value into the count on a sync input and forwards the sync input to its own sync output. Several legs can therefore share one phase reference. Zero events go through a prescaler that raises a sticky interrupt flag on every first, second or third event.

The time base is a two-state machine. In state TB_RISE the count increments, and it moves to TB_FALL when the incremented count reaches the period. In TB_FALL the count decrements, and it returns to TB_RISE when the count steps from 1 to 0. A phase load forces the transition to TB_RISE, or to TB_FALL when the phase value is at or above the period.

Top module: `cpwm_channel`

## Requirements
- R1: The count runs 0,1,…,P,P−1,…,1,0 repeatedly, where P is the active period, so one period lasts 2P cycles; `dir_up` is 1 in state TB_RISE and 0 in TB_FALL. After reset the count is 0, `dir_up` is 1 and P is the PRD_RST parameter.
- R2: For an active compare value C with 0 < C < P, raw wave A goes high in the cycle after the count equals C in TB_RISE and goes low in the cycle after the count equals C in TB_FALL. It is high for 2(P−C) cycles of each period.
- R3: With compare A equal to 0, raw wave A stays low. With compare A at or above P, it stays high. Neither case produces an edge.
- R4: Raw wave B (`raw_b`) is driven low after a compare-B match in TB_RISE and high after a match in TB_FALL. It is held high when compare B is 0 and held low when compare B is at or above P.
- R5: Written period and compare values take effect only on the clock edge at which the count is 0. A period below 2 is loaded as 2.
- R6: `pwm_hi` is high only while raw A is high. It rises `rise_dly` cycles after raw A rises.
- R7: `pwm_lo` is high only while raw A is low. It rises `fall_dly` cycles after raw A falls.
- R8: When a high or low interval of raw A is not longer than the matching delay, the corresponding output stays low for that interval.
- R9: With `phase_en` low, `sync_out` is high exactly in the cycle where the count is 1 in TB_FALL, which is the cycle before the count returns to zero.
- R10: With `phase_en` high, `sync_out` equals `sync_in`. A high `sync_in` loads `phase_val` into the count and the next state is TB_RISE. If `phase_val` is at or above P, the count is loaded with P and the next state is TB_FALL.
- R11: `int_prd` values 1, 2 and 3 set the flag on every first, second or third zero-count cycle, and `evt_cnt` holds the number of zero events counted so far. The value 0 disables the prescaler and holds `evt_cnt` at 0.
- R12: `int_flag` stays set until an `int_clr` pulse clears it. If a set and a clear occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prd_wr | input | 1 | Write strobe for the period holding register |
| prd_wdata | input | CW | New period value |
| cmpa_wr | input | 1 | Write strobe for the compare A holding register |
| cmpa_wdata | input | CW | New compare A value |
| cmpb_wr | input | 1 | Write strobe for the compare B holding register |
| cmpb_wdata | input | CW | New compare B value |
| rise_dly | input | DW | Rising-edge delay for `pwm_hi` in cycles |
| fall_dly | input | DW | Falling-edge delay for `pwm_lo` in cycles |
| phase_en | input | 1 | 1 = slave (phase load and sync pass-through), 0 = master |
| phase_val | input | CW | Count loaded on a slave sync |
| sync_in | input | 1 | Sync input from the upstream channel |
| int_prd | input | 2 | Zero events per interrupt, 0 = off |
| int_clr | input | 1 | Clears the interrupt flag |
| count | output | CW | Current time-base count |
| dir_up | output | 1 | 1 while counting up |
| raw_b | output | 1 | Raw compare-B wave |
| pwm_hi | output | 1 | High-side output after the rising-edge delay |
| pwm_lo | output | 1 | Low-side complementary output after the falling-edge delay |
| sync_out | output | 1 | Sync output to downstream channels |
| int_flag | output | 1 | Sticky interrupt flag |
| evt_cnt | output | 2 | Zero events counted toward the next interrupt |

## Verification
The bench builds the channel with CW = 8, DW = 8 and PRD_RST = 10. A whole switching period then lasts 20 cycles, and a period rewrite to 6 brings it down to 12 cycles. This puts repeated shadow reloads, forced-level compare values (0, equal to P, above P) and pulses shorter than the dead-band delays within a few hundred cycles. With these short periods the bench also sweeps every prescaler ratio, both phase-load cases (inside the period and clamped to P) and the sticky-flag behaviour in one short run, while comparing every output against a cycle model on each clock.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic {
        TB_RISE = 1'b0,
        TB_FALL = 1'b1
    } tb_dir_e;

    localparam int unsigned MIN_PRD = 2;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
#(
    parameter int unsigned CW      = 16,
    parameter int unsigned PRD_RST = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prd_wr,
    input  logic [CW-1:0] prd_wdata,
    input  logic          phase_en,
    input  logic [CW-1:0] phase_val,
    input  logic          sync_in,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] prd_act,
    output tb_dir_e       state,
    output logic          at_zero,
    output logic          sync_out
);
    localparam logic [CW-1:0] PRD_INIT = CW'(PRD_RST);
    localparam logic [CW-1:0] PRD_MIN  = CW'(MIN_PRD);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] prd_sh;
    logic [CW-1:0] cnt_nx;
    logic [CW:0]   cnt_inc;
    tb_dir_e       state_nx;
    logic          phase_hit;

    assign at_zero   = (cnt == '0);
    assign phase_hit = phase_en & sync_in;
    assign cnt_inc   = {1'b0, cnt} + (CW+1)'(1);

    // next-state and next-count logic
    always_comb begin
        cnt_nx   = cnt;
        state_nx = state;
        if (phase_hit) begin
            if (phase_val >= prd_act) begin
                cnt_nx   = prd_act;
                state_nx = TB_FALL;
            end else begin
                cnt_nx   = phase_val;
                state_nx = TB_RISE;
            end
        end else begin
            unique case (state)
                TB_RISE: begin
                    cnt_nx = cnt_inc[CW-1:0];
                    if (cnt_inc >= {1'b0, prd_act}) state_nx = TB_FALL;
                end
                TB_FALL: begin
                    cnt_nx = cnt - ONE;
                    if (cnt <= ONE) state_nx = TB_RISE;
                end
                default: begin
                    cnt_nx   = '0;
                    state_nx = TB_RISE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TB_RISE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // period holding and active registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_sh  <= PRD_INIT;
            prd_act <= PRD_INIT;
        end else begin
            if (prd_wr) prd_sh <= prd_wdata;
            if (at_zero) prd_act <= (prd_sh < PRD_MIN) ? PRD_MIN : prd_sh;
        end
    end

    // outputs
    always_comb begin
        if (phase_en) sync_out = sync_in;
        else          sync_out = (state == TB_FALL) && (cnt == ONE);
    end

    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= prd_act);

    a_r1_fall_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_hit && state == TB_FALL) |=> (cnt == $past(cnt) - ONE));

    a_r5_period_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> $stable(prd_act));
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare
    import cpwm_pkg::*;
#(
    parameter int unsigned CW        = 16,
    parameter bit          SET_ON_UP = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          at_zero,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] prd_act,
    input  tb_dir_e       dir,
    output logic          wave
);
    localparam logic UP_LVL   = SET_ON_UP;
    localparam logic ZERO_LVL = !SET_ON_UP;

    logic [CW-1:0] cmp_sh;
    logic [CW-1:0] cmp_act;
    logic          wave_nx;

    always_comb begin
        wave_nx = wave;
        if (cmp_act == '0)          wave_nx = ZERO_LVL;
        else if (cmp_act >= prd_act) wave_nx = UP_LVL;
        else if (cnt == cmp_act)     wave_nx = (dir == TB_RISE) ? UP_LVL : !UP_LVL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_sh  <= '0;
            cmp_act <= '0;
            wave    <= 1'b0;
        end else begin
            if (wr) cmp_sh <= wdata;
            if (at_zero) cmp_act <= cmp_sh;
            wave <= wave_nx;
        end
    end

    a_r5_compare_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> $stable(cmp_act));
endmodule

// File: rtl/cpwm_edge_delay.sv
module cpwm_edge_delay #(
    parameter int unsigned DW             = 8,
    parameter bit          ACTIVE_ON_HIGH = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [DW-1:0] dly,
    output logic          dout
);
    logic          lvl;
    logic [DW-1:0] run;

    assign lvl = ACTIVE_ON_HIGH ? din : !din;

    // cycles the selected level has been present, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run <= '0;
        else if (!lvl)       run <= '0;
        else if (run != '1)  run <= run + DW'(1);
    end

    assign dout = lvl && (run >= dly);
endmodule

// File: rtl/cpwm_evtscale.sv
module cpwm_evtscale (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       at_zero,
    input  logic [1:0] int_prd,
    input  logic       int_clr,
    output logic       int_flag,
    output logic [1:0] evt_cnt
);
    logic       set_now;
    logic [2:0] evt_inc;

    assign evt_inc = {1'b0, evt_cnt} + 3'd1;
    assign set_now = (int_prd != 2'd0) && at_zero && (evt_inc >= {1'b0, int_prd});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_cnt  <= 2'd0;
            int_flag <= 1'b0;
        end else begin
            if (int_prd == 2'd0)  evt_cnt <= 2'd0;
            else if (set_now)     evt_cnt <= 2'd0;
            else if (at_zero)     evt_cnt <= evt_inc[1:0];
            if (set_now)          int_flag <= 1'b1;
            else if (int_clr)     int_flag <= 1'b0;
        end
    end

    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag && !int_clr) |=> int_flag);

    a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (int_prd == 2'd0) |=> (evt_cnt == 2'd0));
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
    import cpwm_pkg::*;
#(
    parameter int unsigned CW      = 16,
    parameter int unsigned DW      = 8,
    parameter int unsigned PRD_RST = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prd_wr,
    input  logic [CW-1:0] prd_wdata,
    input  logic          cmpa_wr,
    input  logic [CW-1:0] cmpa_wdata,
    input  logic          cmpb_wr,
    input  logic [CW-1:0] cmpb_wdata,
    input  logic [DW-1:0] rise_dly,
    input  logic [DW-1:0] fall_dly,
    input  logic          phase_en,
    input  logic [CW-1:0] phase_val,
    input  logic          sync_in,
    input  logic [1:0]    int_prd,
    input  logic          int_clr,
    output logic [CW-1:0] count,
    output logic          dir_up,
    output logic          raw_b,
    output logic          pwm_hi,
    output logic          pwm_lo,
    output logic          sync_out,
    output logic          int_flag,
    output logic [1:0]    evt_cnt
);
    localparam int unsigned NCMP = 2;

    logic [CW-1:0] prd_act;
    tb_dir_e       state;
    logic          at_zero;
    logic          raw_a;

    logic [NCMP-1:0] cmp_wr_v;
    logic [CW-1:0]   cmp_wd_v [NCMP];
    logic [NCMP-1:0] wave_v;
    logic [DW-1:0]   dly_v    [NCMP];
    logic [NCMP-1:0] db_v;

    cpwm_timebase #(.CW(CW), .PRD_RST(PRD_RST)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .prd_wr    (prd_wr),
        .prd_wdata (prd_wdata),
        .phase_en  (phase_en),
        .phase_val (phase_val),
        .sync_in   (sync_in),
        .cnt       (count),
        .prd_act   (prd_act),
        .state     (state),
        .at_zero   (at_zero),
        .sync_out  (sync_out)
    );

    assign dir_up      = (state == TB_RISE);
    assign cmp_wr_v    = {cmpb_wr, cmpa_wr};
    assign cmp_wd_v[0] = cmpa_wdata;
    assign cmp_wd_v[1] = cmpb_wdata;
    assign dly_v[0]    = rise_dly;
    assign dly_v[1]    = fall_dly;

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        cpwm_compare #(.CW(CW), .SET_ON_UP(g == 0)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (cmp_wr_v[g]),
            .wdata   (cmp_wd_v[g]),
            .at_zero (at_zero),
            .cnt     (count),
            .prd_act (prd_act),
            .dir     (state),
            .wave    (wave_v[g])
        );
    end

    assign raw_a = wave_v[0];
    assign raw_b = wave_v[1];

    for (genvar g = 0; g < NCMP; g++) begin : g_db
        cpwm_edge_delay #(.DW(DW), .ACTIVE_ON_HIGH(g == 0)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_a),
            .dly   (dly_v[g]),
            .dout  (db_v[g])
        );
    end

    assign pwm_hi = db_v[0];
    assign pwm_lo = db_v[1];

    cpwm_evtscale u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .at_zero  (at_zero),
        .int_prd  (int_prd),
        .int_clr  (int_clr),
        .int_flag (int_flag),
        .evt_cnt  (evt_cnt)
    );

    a_r6_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_hi && pwm_lo));

    a_r8_hi_inside_raw: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_hi |-> raw_a);

    a_r7_lo_inside_gap: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_lo |-> !raw_a);

    a_r9_master_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_en && sync_out) |=> (count == '0));

    a_r10_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en && sync_in && phase_val < prd_act) |=> (count == $past(phase_val)));
endmodule

// File: tb/cpwm_channel_bench.sv
`timescale 1ns/1ps
module cpwm_channel_bench;
    localparam int CW  = 8;
    localparam int DW  = 8;
    localparam int PRD0 = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prd_wr = 1'b0;
    logic [CW-1:0] prd_wdata = '0;
    logic          cmpa_wr = 1'b0;
    logic [CW-1:0] cmpa_wdata = '0;
    logic          cmpb_wr = 1'b0;
    logic [CW-1:0] cmpb_wdata = '0;
    logic [DW-1:0] rise_dly = '0;
    logic [DW-1:0] fall_dly = '0;
    logic          phase_en = 1'b0;
    logic [CW-1:0] phase_val = '0;
    logic          sync_in = 1'b0;
    logic [1:0]    int_prd = 2'd0;
    logic          int_clr = 1'b0;
    logic [CW-1:0] count;
    logic          dir_up, raw_b, pwm_hi, pwm_lo, sync_out, int_flag;
    logic [1:0]    evt_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpwm_channel #(.CW(CW), .DW(DW), .PRD_RST(PRD0)) u_cpwm_channel (
        .clk(clk), .rst_n(rst_n),
        .prd_wr(prd_wr), .prd_wdata(prd_wdata),
        .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata),
        .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata),
        .rise_dly(rise_dly), .fall_dly(fall_dly),
        .phase_en(phase_en), .phase_val(phase_val), .sync_in(sync_in),
        .int_prd(int_prd), .int_clr(int_clr),
        .count(count), .dir_up(dir_up), .raw_b(raw_b),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .sync_out(sync_out),
        .int_flag(int_flag), .evt_cnt(evt_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model, state before the current edge
    int m_cnt, m_prd, m_prd_sh, m_ca, m_ca_sh, m_cb, m_cb_sh, m_rh, m_rl, m_ev;
    bit m_fall, m_ra, m_rb, m_flag;
    int n_cnt;
    bit n_fall, n_ra, n_rb, z, set_ev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_fall = 0; m_prd = PRD0; m_prd_sh = PRD0;
            m_ca = 0; m_ca_sh = 0; m_cb = 0; m_cb_sh = 0;
            m_ra = 0; m_rb = 0; m_rh = 0; m_rl = 0; m_ev = 0; m_flag = 0;
        end else begin
            z = (m_cnt == 0);
            n_ra = m_ra;
            if (m_ca == 0) n_ra = 0;
            else if (m_ca >= m_prd) n_ra = 1;
            else if (m_cnt == m_ca) n_ra = !m_fall;
            n_rb = m_rb;
            if (m_cb == 0) n_rb = 1;
            else if (m_cb >= m_prd) n_rb = 0;
            else if (m_cnt == m_cb) n_rb = m_fall;
            m_rh = m_ra ? ((m_rh < 255) ? m_rh + 1 : 255) : 0;
            m_rl = !m_ra ? ((m_rl < 255) ? m_rl + 1 : 255) : 0;
            set_ev = 0;
            if (int_prd == 0) m_ev = 0;
            else if (z) begin
                if (m_ev + 1 >= int_prd) begin m_ev = 0; set_ev = 1; end
                else m_ev = m_ev + 1;
            end
            if (set_ev) m_flag = 1;
            else if (int_clr) m_flag = 0;
            if (phase_en && sync_in) begin
                if (int'(phase_val) >= m_prd) begin n_cnt = m_prd; n_fall = 1; end
                else begin n_cnt = int'(phase_val); n_fall = 0; end
            end else if (!m_fall) begin
                n_cnt = m_cnt + 1; n_fall = (m_cnt + 1 >= m_prd);
            end else begin
                n_cnt = m_cnt - 1; n_fall = !(m_cnt <= 1);
            end
            if (z) begin
                m_prd = (m_prd_sh < 2) ? 2 : m_prd_sh;
                m_ca = m_ca_sh; m_cb = m_cb_sh;
            end
            if (prd_wr) m_prd_sh = int'(prd_wdata);
            if (cmpa_wr) m_ca_sh = int'(cmpa_wdata);
            if (cmpb_wr) m_cb_sh = int'(cmpb_wdata);
            m_cnt = n_cnt; m_fall = n_fall; m_ra = n_ra; m_rb = n_rb;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_hi, e_lo, e_sync;
            e_hi = m_ra && (m_rh >= int'(rise_dly));
            e_lo = !m_ra && (m_rl >= int'(fall_dly));
            e_sync = phase_en ? sync_in : (m_fall && m_cnt == 1);
            chk(int'(count) == m_cnt, "R1,R5 count", int'(count), m_cnt);
            chk(dir_up == !m_fall, "R1 dir_up", dir_up, !m_fall);
            chk(pwm_hi == e_hi, "R2,R3,R6,R8 pwm_hi", pwm_hi, e_hi);
            chk(pwm_lo == e_lo, "R7,R8 pwm_lo", pwm_lo, e_lo);
            chk(raw_b == m_rb, "R4 raw_b", raw_b, m_rb);
            chk(sync_out == e_sync, "R9,R10 sync_out", sync_out, e_sync);
            chk(int_flag == m_flag, "R11,R12 int_flag", int_flag, m_flag);
            chk(int'(evt_cnt) == m_ev, "R11 evt_cnt", int'(evt_cnt), m_ev);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_cmpa(input int v);
        cmpa_wdata = CW'(v); cmpa_wr = 1'b1; tick(1); cmpa_wr = 1'b0;
    endtask

    task automatic wr_cmpb(input int v);
        cmpb_wdata = CW'(v); cmpb_wr = 1'b1; tick(1); cmpb_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        int_clr = 1'b1; tick(1); int_clr = 1'b0;
    endtask

    // counts high cycles of a chosen output: 0 pwm_hi, 1 pwm_lo, 2 raw_b
    task automatic count_sig(input int n, input int which, output int hits);
        hits = 0;
        repeat (n) begin
            @(negedge clk);
            case (which)
                0: hits += int'(pwm_hi);
                1: hits += int'(pwm_lo);
                default: hits += int'(raw_b);
            endcase
        end
        #1;
    endtask

    task automatic sync_gap(output int gap);
        do @(negedge clk); while (!sync_out);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!sync_out);
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int h;
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count == '0, "R1 reset count", int'(count), 0);
        chk(dir_up == 1'b1, "R1 reset dir_up", dir_up, 1);
        chk(int_flag == 1'b0, "R11 reset flag", int_flag, 0);
        #1;

        // base pattern, no dead band
        int_prd = 2'd1;
        wr_cmpa(4); wr_cmpb(6);
        tick(45);
        count_sig(20, 0, h); chk(h == 12, "R2 high cycles C=4 P=10", h, 12);
        count_sig(20, 2, h); chk(h == 12, "R4 raw_b high cycles C=6", h, 12);

        // forced levels
        wr_cmpa(0); tick(45);
        count_sig(20, 0, h); chk(h == 0, "R3 compare 0 stays low", h, 0);
        wr_cmpa(10); tick(45);
        count_sig(20, 0, h); chk(h == 20, "R3 compare equal to P stays high", h, 20);
        wr_cmpa(15); wr_cmpb(0); tick(45);
        count_sig(20, 0, h); chk(h == 20, "R3 compare above P stays high", h, 20);
        count_sig(20, 2, h); chk(h == 20, "R4 compare B 0 held high", h, 20);
        wr_cmpb(12); tick(45);
        count_sig(20, 2, h); chk(h == 0, "R4 compare B above P held low", h, 0);
        @(negedge clk);
        chk(int_flag == 1'b1, "R12 flag sticky without clear", int_flag, 1);
        #1;
        pulse_clr();

        // dead band
        wr_cmpa(4); wr_cmpb(6);
        rise_dly = 8'd2; fall_dly = 8'd3;
        tick(45);
        count_sig(20, 0, h); chk(h == 10, "R6 rising delay 2", h, 10);
        count_sig(20, 1, h); chk(h == 5, "R7 falling delay 3", h, 5);
        wr_cmpa(9); rise_dly = 8'd5; tick(45);
        count_sig(20, 0, h); chk(h == 0, "R8 short high pulse suppressed", h, 0);
        wr_cmpa(1); rise_dly = 8'd2; fall_dly = 8'd5; tick(45);
        count_sig(20, 1, h); chk(h == 0, "R8 short low pulse suppressed", h, 0);

        // period change takes effect at zero
        wr_cmpa(4); fall_dly = 8'd3;
        tick(7);
        prd_wdata = 8'd6; prd_wr = 1'b1; tick(1); prd_wr = 1'b0;
        tick(40);
        sync_gap(h); chk(h == 12, "R1,R5,R9 period after rewrite", h, 12);
        prd_wdata = 8'd1; prd_wr = 1'b1; tick(1); prd_wr = 1'b0;
        tick(30);
        sync_gap(h); chk(h == 4, "R5 period clamped to 2", h, 4);
        prd_wdata = 8'd6; prd_wr = 1'b1; tick(1); prd_wr = 1'b0;
        tick(20);

        // prescaler ratios
        int_prd = 2'd3; pulse_clr();
        repeat (6) begin tick(9); pulse_clr(); end
        int_prd = 2'd2;
        repeat (6) begin tick(7); pulse_clr(); end

        // slave phase load
        phase_en = 1'b1; phase_val = 8'd3; tick(3);
        sync_in = 1'b1;
        @(negedge clk);
        chk(sync_out == 1'b1, "R10 sync passes through", sync_out, 1);
        @(posedge clk); #1 sync_in = 1'b0;
        @(negedge clk);
        chk(int'(count) == 3, "R10 phase loaded", int'(count), 3);
        #1;
        tick(10);
        phase_val = 8'd20; sync_in = 1'b1; tick(1); sync_in = 1'b0;
        @(negedge clk);
        chk(int'(count) == 6, "R10 phase clamped to P", int'(count), 6);
        chk(dir_up == 1'b0, "R10 clamp counts down", dir_up, 0);
        #1;
        tick(10);
        phase_en = 1'b0;
        int_prd = 2'd0; pulse_clr();
        tick(30);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule